// File: doc/BRIEF.md
# Interrupt Source Delivery Router

This block keeps two 32-bit control words for each of a set of interrupt inputs. The configuration word holds mask, mode, polarity, sense, priority and vector. The target word holds a bitmap of CPUs and a critical flag. Every cycle the block samples each input as either level- or edge-sensitive and keeps a pending flag per source. From the sources that may be delivered, it picks one: the highest priority wins, and among equal priorities the lowest index wins. It then hands that source to the CPU interfaces as a one-cycle offer carrying the source index, priority and vector.

A mode bit selects how the chosen source is routed. In directed mode it is broadcast to every CPU in the bitmap. In distributed mode a search runs round-robin through the bitmap, starting after the CPU that was served last. An offered source becomes active and is not offered again until the acknowledge logic, which sits outside this block, retires it through the retire port. A level source whose input drops also loses its active state.

Software reaches both words of each source through a plain 32-bit register port. Source i sits at byte offset 32·i: the configuration word is at +0 and the target word at +16.

Top module: `irq_router`

## Requirements
- R1: After reset, every configuration word reads 0x80000000 (masked), every target word reads 0x00000001, and no offer strobe is high.
- R2: A configuration-word write stores only mask (bit 31), mode (bit 29), polarity (bit 23), sense (bit 22, 1 = level), priority (bits 19:16) and vector (bits 7:0). The active bit (bit 30) keeps its value, and all other bits read as 0. Writing all ones to an idle source reads back 0xA0CF00FF.
- R3: A target-word write keeps bits 31:30 and one CPU bit per CPU (bits N_CPU-1:0), and discards the rest. With four CPUs, all ones reads back 0xC000000F.
- R4: The configuration word of source i is at byte address 32·i and its target word at 32·i+16. A write to any address whose bits 3:0 are not zero changes nothing, and a read of such an address returns 0xFFFFFFFF.
- R5: The effective input is the pin XOR polarity. Under level sense, pending follows the effective input, and a low effective input clears the active bit. Under edge sense, a rising effective input sets pending, and the input never clears it.
- R6: A source is not offered while it is not pending, is masked, has priority 0, is active, or has an empty CPU bitmap. The decision is made again after every register write, so a pending source that becomes unblocked is then offered.
- R7: An offer appears on the second rising edge after the edge that samples the input, or the edge that applies the unblocking write. It lasts one cycle and sets the source's active bit.
- R8: At most one source is offered per cycle. It is the eligible source with the highest priority, and the lowest index among equal priorities.
- R9: In mode 0 the source is offered to every CPU whose bitmap bit is set.
- R10: In mode 1 the search starts at last CPU + 1, wraps at the CPU count, offers to the first CPU found and records it as the last CPU. A bitmap holding only the last CPU's bit sends the source to that CPU.
- R11: When critical support is on, target-word bit (30 − c) routes an offer for CPU c to offer_crit[c] instead of offer_valid[c].
- R12: A retire strobe for a source clears its active bit. For an edge source it also clears pending, while a level source stays pending as long as its input is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | N_SRC | Raw interrupt inputs, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | SRC_W+5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| done_valid | input | 1 | Retire strobe from the acknowledge logic |
| done_src | input | SRC_W | Source index being retired |
| offer_valid | output | N_CPU | Per-CPU normal offer strobe |
| offer_crit | output | N_CPU | Per-CPU critical offer strobe |
| offer_src | output | SRC_W | Index of the offered source |
| offer_prio | output | 4 | Priority of the offered source |
| offer_vector | output | 8 | Vector of the offered source |

## Verification
Routing is tried with a mixed bitmap in directed mode and a sparse bitmap in distributed mode. Four successive distributed deliveries show whether the search skips holes and wraps. A bitmap holding only the last CPU's bit separates the last-CPU shortcut from the search, which would find nothing. Three sources raised in the same cycle, two of them sharing the top priority, expose the order of priority and index in arbitration. Level and edge inputs held high across a retire show which sense keeps pending alive. Each gating condition is first set while the source is pending and then lifted by a write, which tells a block that latches its decision apart from one that re-evaluates.

// File: rtl/irq_router_pkg.sv
// Shared field positions, reset words and encode/decode helpers for the
// interrupt source router. Assumes the 32-bit configuration word layout
// described in the brief; nothing here holds state.
package irq_router_pkg;

    localparam int VP_MASK_BIT  = 31;
    localparam int VP_ACT_BIT   = 30;
    localparam int VP_MODE_BIT  = 29;
    localparam int VP_POL_BIT   = 23;
    localparam int VP_SENSE_BIT = 22;
    localparam int VP_PRIO_LSB  = 16;
    localparam int PRIO_W       = 4;
    localparam int VEC_W        = 8;
    localparam int DST_CRIT_BIT = 30;

    localparam logic [31:0] VP_RESET  = 32'h8000_0000;
    localparam logic [31:0] DST_RESET = 32'h0000_0001;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [VEC_W-1:0]  vec_t;

    typedef struct packed {
        logic  mask;
        logic  mode;
        logic  pol;
        logic  sense;
        prio_t prio;
        vec_t  vec;
    } vp_cfg_t;

    // Pull the software-writable fields out of a configuration word.
    function automatic vp_cfg_t vp_decode(input logic [31:0] w);
        vp_cfg_t c;
        c.mask  = w[VP_MASK_BIT];
        c.mode  = w[VP_MODE_BIT];
        c.pol   = w[VP_POL_BIT];
        c.sense = w[VP_SENSE_BIT];
        c.prio  = w[VP_PRIO_LSB +: PRIO_W];
        c.vec   = w[VEC_W-1:0];
        return c;
    endfunction

    // Assemble the readable configuration word from fields and activity.
    function automatic logic [31:0] vp_encode(input vp_cfg_t c, input logic act);
        logic [31:0] w;
        w = '0;
        w[VP_MASK_BIT]              = c.mask;
        w[VP_ACT_BIT]               = act;
        w[VP_MODE_BIT]              = c.mode;
        w[VP_POL_BIT]               = c.pol;
        w[VP_SENSE_BIT]             = c.sense;
        w[VP_PRIO_LSB +: PRIO_W]    = c.prio;
        w[VEC_W-1:0]                = c.vec;
        return w;
    endfunction

endpackage

// File: rtl/irq_src_slot.sv
// One interrupt source: configuration and target words, input sampling,
// pending/active state, last-served CPU and the eligibility decision.
// Assumes N_CPU <= 30 so the CPU bitmap does not overlap bits 31:30.
module irq_src_slot
    import irq_router_pkg::*;
#(
    parameter int N_CPU   = 4,
    parameter int CRIT_EN = 1,
    parameter int CPU_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_i,
    input  logic             wr_vp_i,
    input  logic             wr_dst_i,
    input  logic [31:0]      wdata_i,
    input  logic             retire_i,
    input  logic             deliver_i,
    input  logic [CPU_W-1:0] new_last_i,
    output logic [31:0]      vp_word_o,
    output logic [31:0]      dst_word_o,
    output logic             elig_o,
    output prio_t            prio_o,
    output vec_t             vec_o,
    output logic             mode_o,
    output logic [N_CPU-1:0] dcpu_o,
    output logic [N_CPU-1:0] crit_o,
    output logic [CPU_W-1:0] last_o
);

    vp_cfg_t          cfg_q;
    logic [1:0]       dhi_q;
    logic [N_CPU-1:0] dcpu_q;
    logic [CPU_W-1:0] last_q;
    logic             act_q;
    logic             pend_q;
    logic             prev_q;
    logic             eff;
    logic             rise;
    logic             unused_wbits;

    assign unused_wbits = ^wdata_i;

    // Effective input after polarity, and its rising edge.
    assign eff  = irq_i ^ cfg_q.pol;
    assign rise = eff & ~prev_q;

    // Software-visible configuration and target words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= vp_decode(VP_RESET);
            dhi_q  <= DST_RESET[31:30];
            dcpu_q <= DST_RESET[N_CPU-1:0];
        end else begin
            if (wr_vp_i)  cfg_q <= vp_decode(wdata_i);
            if (wr_dst_i) begin
                dhi_q  <= wdata_i[31:30];
                dcpu_q <= wdata_i[N_CPU-1:0];
            end
        end
    end

    // Pending follows the input (level) or latches rising edges (edge).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            prev_q <= eff;
            if (cfg_q.sense)   pend_q <= eff;
            else if (rise)     pend_q <= 1'b1;
            else if (retire_i) pend_q <= 1'b0;
        end
    end

    // Active is set by delivery, cleared by retire or a low level input.
    always_ff @(posedge clk) begin
        if (!rst_n)                                act_q <= 1'b0;
        else if (deliver_i)                        act_q <= 1'b1;
        else if (retire_i || (cfg_q.sense && !eff)) act_q <= 1'b0;
    end

    // Last CPU served, updated on each delivery.
    always_ff @(posedge clk) begin
        if (!rst_n)         last_q <= '0;
        else if (deliver_i) last_q <= new_last_i;
    end

    // Readable words.
    assign vp_word_o = vp_encode(cfg_q, act_q);

    always_comb begin
        dst_word_o              = '0;
        dst_word_o[31:30]       = dhi_q;
        dst_word_o[N_CPU-1:0]   = dcpu_q;
    end

    // Eligibility: pending, unmasked, nonzero priority, idle, has a target.
    assign elig_o = pend_q && !cfg_q.mask && (cfg_q.prio != '0) && !act_q && (|dcpu_q);
    assign prio_o = cfg_q.prio;
    assign vec_o  = cfg_q.vec;
    assign mode_o = cfg_q.mode;
    assign dcpu_o = dcpu_q;
    assign last_o = last_q;

    // Per-CPU critical flag taken from the target word.
    for (genvar c = 0; c < N_CPU; c++) begin : g_crit
        if (CRIT_EN != 0 && (DST_CRIT_BIT - c) >= 0) begin : g_on
            assign crit_o[c] = dst_word_o[DST_CRIT_BIT - c];
        end else begin : g_off
            assign crit_o[c] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
// Chooses one eligible source: highest priority, lowest index on ties.
// Purely combinational; assumes elig and prio vectors are index-aligned.
module irq_prio_pick
    import irq_router_pkg::*;
#(
    parameter int N_SRC = 64,
    parameter int SRC_W = 6
) (
    input  logic [N_SRC-1:0]        elig_i,
    input  prio_t [N_SRC-1:0]       prio_i,
    output logic                    valid_o,
    output logic [SRC_W-1:0]        idx_o
);

    prio_t best;

    // Linear scan, ascending index, strict greater-than keeps lower index.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        best    = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig_i[i] && (!valid_o || prio_i[i] > best)) begin
                valid_o = 1'b1;
                idx_o   = SRC_W'(i);
                best    = prio_i[i];
            end
        end
    end

endmodule

// File: rtl/irq_cpu_route.sv
// Turns a CPU bitmap, last-served CPU and mode into the set of CPUs to
// offer to and the new last-served CPU. Assumes the bitmap is nonzero and
// last_i < N_CPU.
module irq_cpu_route #(
    parameter int N_CPU = 4,
    parameter int CPU_W = 2
) (
    input  logic [N_CPU-1:0] dcpu_i,
    input  logic [CPU_W-1:0] last_i,
    input  logic             mode_i,
    output logic [N_CPU-1:0] mask_o,
    output logic [CPU_W-1:0] last_o
);

    logic only_last;
    logic found;
    int   idx;

    // Shortcut, broadcast, or round-robin search after the last CPU.
    always_comb begin
        mask_o    = '0;
        last_o    = last_i;
        found     = 1'b0;
        idx       = 0;
        only_last = 1'b1;
        for (int c = 0; c < N_CPU; c++) begin
            if (dcpu_i[c] != (CPU_W'(c) == last_i)) only_last = 1'b0;
        end
        if (only_last) begin
            mask_o[last_i] = 1'b1;
        end else if (!mode_i) begin
            mask_o = dcpu_i;
        end else begin
            for (int k = 1; k < N_CPU; k++) begin
                idx = int'(last_i) + k;
                if (idx >= N_CPU) idx = idx - N_CPU;
                if (!found && dcpu_i[idx]) begin
                    found       = 1'b1;
                    mask_o[idx] = 1'b1;
                    last_o      = CPU_W'(idx);
                end
            end
        end
    end

endmodule

// File: rtl/irq_router.sv
// Top of the interrupt source router: register decode and read mux, one
// slot per source, the arbiter, the CPU router and the registered offers.
// Assumes one offer per cycle is enough for the attached CPU interfaces.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int N_SRC   = 64,
    parameter int N_CPU   = 4,
    parameter int CRIT_EN = 1,
    localparam int SRC_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int CPU_W  = (N_CPU > 1) ? $clog2(N_CPU) : 1,
    localparam int AW     = SRC_W + 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_in,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             done_valid,
    input  logic [SRC_W-1:0] done_src,
    output logic [N_CPU-1:0] offer_valid,
    output logic [N_CPU-1:0] offer_crit,
    output logic [SRC_W-1:0] offer_src,
    output logic [3:0]       offer_prio,
    output logic [7:0]       offer_vector
);

    logic [N_SRC-1:0][31:0]      vp_all;
    logic [N_SRC-1:0][31:0]      dst_all;
    logic [N_SRC-1:0]            elig_all;
    prio_t [N_SRC-1:0]           prio_all;
    vec_t  [N_SRC-1:0]           vec_all;
    logic [N_SRC-1:0]            mode_all;
    logic [N_SRC-1:0][N_CPU-1:0] dcpu_all;
    logic [N_SRC-1:0][N_CPU-1:0] crit_all;
    logic [N_SRC-1:0][CPU_W-1:0] last_all;

    logic [SRC_W-1:0] reg_idx;
    logic             aligned;
    logic             pick_dst;
    logic             sel_valid;
    logic [SRC_W-1:0] sel_idx;
    logic             sel_mode;
    logic [N_CPU-1:0] sel_dcpu;
    logic [N_CPU-1:0] sel_crit;
    logic [CPU_W-1:0] sel_last;
    logic [N_CPU-1:0] route_mask;
    logic [CPU_W-1:0] route_last;

    // Address decode: word-aligned only, bit 4 picks the target word.
    assign reg_idx  = reg_addr[AW-1:5];
    assign aligned  = (reg_addr[3:0] == 4'h0);
    assign pick_dst = reg_addr[4];

    // One slot per source.
    for (genvar gi = 0; gi < N_SRC; gi++) begin : g_src
        logic hit;
        assign hit = reg_wr && aligned && (reg_idx == SRC_W'(gi));
        irq_src_slot #(
            .N_CPU   (N_CPU),
            .CRIT_EN (CRIT_EN),
            .CPU_W   (CPU_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .irq_i      (irq_in[gi]),
            .wr_vp_i    (hit && !pick_dst),
            .wr_dst_i   (hit && pick_dst),
            .wdata_i    (reg_wdata),
            .retire_i   (done_valid && (done_src == SRC_W'(gi))),
            .deliver_i  (sel_valid && (sel_idx == SRC_W'(gi))),
            .new_last_i (route_last),
            .vp_word_o  (vp_all[gi]),
            .dst_word_o (dst_all[gi]),
            .elig_o     (elig_all[gi]),
            .prio_o     (prio_all[gi]),
            .vec_o      (vec_all[gi]),
            .mode_o     (mode_all[gi]),
            .dcpu_o     (dcpu_all[gi]),
            .crit_o     (crit_all[gi]),
            .last_o     (last_all[gi])
        );
    end

    // Register read mux; misaligned or out-of-range reads return all ones.
    always_comb begin
        reg_rdata = 32'hFFFF_FFFF;
        if (aligned && (int'(reg_idx) < N_SRC)) begin
            reg_rdata = pick_dst ? dst_all[reg_idx] : vp_all[reg_idx];
        end
    end

    irq_prio_pick #(
        .N_SRC (N_SRC),
        .SRC_W (SRC_W)
    ) u_pick (
        .elig_i  (elig_all),
        .prio_i  (prio_all),
        .valid_o (sel_valid),
        .idx_o   (sel_idx)
    );

    // Fields of the selected source.
    assign sel_mode = mode_all[sel_idx];
    assign sel_dcpu = dcpu_all[sel_idx];
    assign sel_crit = crit_all[sel_idx];
    assign sel_last = last_all[sel_idx];

    irq_cpu_route #(
        .N_CPU (N_CPU),
        .CPU_W (CPU_W)
    ) u_route (
        .dcpu_i (sel_dcpu),
        .last_i (sel_last),
        .mode_i (sel_mode),
        .mask_o (route_mask),
        .last_o (route_last)
    );

    // Registered one-cycle offers, split into normal and critical.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offer_valid  <= '0;
            offer_crit   <= '0;
            offer_src    <= '0;
            offer_prio   <= '0;
            offer_vector <= '0;
        end else begin
            offer_valid <= sel_valid ? (route_mask & ~sel_crit) : '0;
            offer_crit  <= sel_valid ? (route_mask & sel_crit) : '0;
            if (sel_valid) begin
                offer_src    <= sel_idx;
                offer_prio   <= prio_all[sel_idx];
                offer_vector <= vec_all[sel_idx];
            end
        end
    end

endmodule

// File: rtl/irq_router_chk.sv
// Temporal checks on the router's offers, bound to every irq_router.
module irq_router_chk #(
    parameter int N_CPU = 4,
    parameter int SRC_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       addr_lo,
    input logic [31:0]      reg_rdata,
    input logic [N_CPU-1:0] offer_valid,
    input logic [N_CPU-1:0] offer_crit,
    input logic [SRC_W-1:0] offer_src,
    input logic [3:0]       offer_prio,
    input logic             sel_valid,
    input logic             sel_mode,
    input logic [N_CPU-1:0] sel_dcpu
);

    logic [N_CPU-1:0] any_offer;
    assign any_offer = offer_valid | offer_crit;

    // R4
    misaligned_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_lo != 4'h0) |-> (reg_rdata == 32'hFFFF_FFFF));

    // R6
    offer_prio_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|any_offer) |-> (offer_prio != 4'h0));

    // R7
    offer_from_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|any_offer) |-> $past(sel_valid));

    // R7
    no_repeat_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|any_offer) |=> !((|any_offer) && (offer_src == $past(offer_src))));

    // R9
    offer_within_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |=> ((any_offer & ~$past(sel_dcpu)) == '0));

    // R10
    spread_single_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && sel_mode) |=> ($countones(any_offer) == 1));

endmodule

bind irq_router irq_router_chk #(
    .N_CPU (N_CPU),
    .SRC_W (SRC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_lo     (reg_addr[3:0]),
    .reg_rdata   (reg_rdata),
    .offer_valid (offer_valid),
    .offer_crit  (offer_crit),
    .offer_src   (offer_src),
    .offer_prio  (offer_prio),
    .sel_valid   (sel_valid),
    .sel_mode    (sel_mode),
    .sel_dcpu    (sel_dcpu)
);

// File: tb/irq_router_bench.sv
// Directed bench for irq_router: one task per scenario, each self-checking.
module irq_router_bench;

    localparam int N_SRC = 64;
    localparam int N_CPU = 4;
    localparam int SRC_W = 6;
    localparam int AW    = SRC_W + 5;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [N_SRC-1:0] irq_in;
    logic             reg_wr;
    logic [AW-1:0]    reg_addr;
    logic [31:0]      reg_wdata;
    logic [31:0]      reg_rdata;
    logic             done_valid;
    logic [SRC_W-1:0] done_src;
    logic [N_CPU-1:0] offer_valid;
    logic [N_CPU-1:0] offer_crit;
    logic [SRC_W-1:0] offer_src;
    logic [3:0]       offer_prio;
    logic [7:0]       offer_vector;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    irq_router #(.N_SRC(N_SRC), .N_CPU(N_CPU), .CRIT_EN(1)) u_irq_router (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_in       (irq_in),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .done_valid   (done_valid),
        .done_src     (done_src),
        .offer_valid  (offer_valid),
        .offer_crit   (offer_crit),
        .offer_src    (offer_src),
        .offer_prio   (offer_prio),
        .offer_vector (offer_vector)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_raw(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr(input int idx, input bit dst, input logic [31:0] d);
        wr_raw(AW'(idx * 32 + (dst ? 16 : 0)), d);
    endtask

    task automatic rd_raw(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic rd(input string tag, input int idx, input bit dst, input logic [31:0] exp);
        rd_raw(tag, AW'(idx * 32 + (dst ? 16 : 0)), exp);
    endtask

    task automatic pulse(input int idx);
        @(negedge clk); irq_in[idx] = 1'b1;
        @(negedge clk); irq_in[idx] = 1'b0;
    endtask

    task automatic set_irq(input int idx, input logic v);
        @(negedge clk); irq_in[idx] = v;
        @(negedge clk);
    endtask

    task automatic retire(input int idx);
        @(negedge clk); done_valid = 1'b1; done_src = SRC_W'(idx);
        @(negedge clk); done_valid = 1'b0;
    endtask

    task automatic quiet_now(input string tag);
        chk(tag, {24'h0, offer_crit, offer_valid}, 32'h0);
    endtask

    // Offer is registered on the next rising edge; sample at the negedge after it.
    task automatic look(input string tag, input logic [3:0] ev, input logic [3:0] ec,
                        input int es, input logic [3:0] ep);
        @(posedge clk); @(negedge clk);
        chk({tag, " valid"}, {28'h0, offer_valid}, {28'h0, ev});
        chk({tag, " crit"},  {28'h0, offer_crit},  {28'h0, ec});
        chk({tag, " src"},   {26'h0, offer_src},   32'(es));
        chk({tag, " prio"},  {28'h0, offer_prio},  {28'h0, ep});
    endtask

    task automatic look_none(input string tag);
        @(posedge clk); @(negedge clk);
        quiet_now(tag);
    endtask

    task automatic t_reset();
        rd("R1 cfg word reset", 5, 0, 32'h8000_0000);
        rd("R1 target word reset", 5, 1, 32'h0000_0001);
        quiet_now("R1 no offer at reset");
    endtask

    task automatic t_write_masks();
        wr(9, 0, 32'hFFFF_FFFF);
        rd("R2 cfg write mask", 9, 0, 32'hA0CF_00FF);
        wr(9, 1, 32'hFFFF_FFFF);
        rd("R3 target write mask", 9, 1, 32'hC000_000F);
        wr(9, 0, 32'h8000_0000);
        wr(9, 1, 32'h0000_0001);
    endtask

    task automatic t_misaligned();
        wr_raw(AW'(2 * 32 + 4), 32'h0000_0000);
        rd("R4 misaligned write ignored", 2, 0, 32'h8000_0000);
        rd_raw("R4 misaligned read +4", AW'(2 * 32 + 4), 32'hFFFF_FFFF);
        rd_raw("R4 misaligned read +20", AW'(2 * 32 + 20), 32'hFFFF_FFFF);
    endtask

    task automatic t_directed();
        wr(3, 1, 32'h0000_0006);
        wr(3, 0, 32'h0005_0033);
        pulse(3);
        look("R9 directed broadcast", 4'b0110, 4'b0000, 3, 4'd5);
        chk("R9 vector", {24'h0, offer_vector}, 32'h33);
        @(negedge clk);
        quiet_now("R7 single-cycle strobe");
        rd("R7 activity set after offer", 3, 0, 32'h4005_0033);
        pulse(3);
        look_none("R6 active source not re-offered");
        retire(3);
        look_none("R12 edge pending cleared by retire");
        rd("R12 retire clears activity", 3, 0, 32'h0005_0033);
    endtask

    task automatic t_gating();
        wr(4, 0, 32'h0000_0000);
        pulse(4);
        look_none("R6 priority zero blocks");
        wr(4, 0, 32'h8002_0000);
        look_none("R6 mask blocks");
        wr(4, 0, 32'h0002_0000);
        look("R6 unmask re-evaluates pending", 4'b0001, 4'b0000, 4, 4'd2);
        retire(4);
        wr(6, 1, 32'h0000_0000);
        wr(6, 0, 32'h0001_0000);
        pulse(6);
        look_none("R6 empty bitmap blocks");
        wr(6, 1, 32'h0000_0002);
        look("R6 bitmap write re-evaluates", 4'b0010, 4'b0000, 6, 4'd1);
        retire(6);
        wr(8, 0, 32'h0001_0000);
        look_none("R6 not pending blocks");
    endtask

    task automatic t_round_robin();
        logic [3:0] exp_map [4];
        exp_map[0] = 4'b0010; exp_map[1] = 4'b1000;
        exp_map[2] = 4'b0001; exp_map[3] = 4'b0010;
        wr(7, 1, 32'h0000_000B);
        wr(7, 0, 32'h2003_0000);
        for (int n = 0; n < 4; n++) begin
            pulse(7);
            look($sformatf("R10 round robin step %0d", n), exp_map[n], 4'b0000, 7, 4'd3);
            retire(7);
        end
        wr(7, 1, 32'h0000_0002);
        pulse(7);
        look("R10 only last cpu in bitmap", 4'b0010, 4'b0000, 7, 4'd3);
        retire(7);
    endtask

    task automatic t_level();
        wr(10, 0, 32'h0044_0000);
        set_irq(10, 1'b1);
        look("R5 level offer", 4'b0001, 4'b0000, 10, 4'd4);
        @(negedge clk);
        quiet_now("R5 level held high no repeat");
        retire(10);
        look("R12 level re-offer while high", 4'b0001, 4'b0000, 10, 4'd4);
        set_irq(10, 1'b0);
        @(negedge clk);
        quiet_now("R5 level low no offer");
        rd("R5 level low clears activity", 10, 0, 32'h0044_0000);
        wr(11, 0, 32'h00C1_0000);
        @(posedge clk);
        look("R5 inverted polarity low input", 4'b0001, 4'b0000, 11, 4'd1);
        set_irq(11, 1'b1);
        @(negedge clk);
        rd("R5 inverted polarity deassert", 11, 0, 32'h00C1_0000);
        quiet_now("R5 inverted polarity no offer");
    endtask

    task automatic t_arbitration();
        wr(20, 0, 32'h0003_0020);
        wr(21, 0, 32'h0007_0021);
        wr(22, 0, 32'h0007_0022);
        @(negedge clk);
        irq_in[20] = 1'b1; irq_in[21] = 1'b1; irq_in[22] = 1'b1;
        @(negedge clk);
        irq_in[20] = 1'b0; irq_in[21] = 1'b0; irq_in[22] = 1'b0;
        look("R8 first highest prio low index", 4'b0001, 4'b0000, 21, 4'd7);
        @(negedge clk);
        chk("R8 second pick", {26'h0, offer_src}, 32'd22);
        @(negedge clk);
        chk("R8 third pick", {26'h0, offer_src}, 32'd20);
        chk("R8 third pick prio", {28'h0, offer_prio}, 32'd3);
        retire(20); retire(21); retire(22);
    endtask

    task automatic t_critical();
        wr(12, 1, 32'h4000_0005);
        wr(12, 0, 32'h0006_0000);
        pulse(12);
        look("R11 critical split", 4'b0100, 4'b0001, 12, 4'd6);
        retire(12);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; irq_in = '0; reg_wr = 1'b0; reg_addr = '0;
        reg_wdata = '0; done_valid = 1'b0; done_src = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_write_masks();
        t_misaligned();
        t_directed();
        t_gating();
        t_round_robin();
        t_level();
        t_arbitration();
        t_critical();
        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule